// File: doc/BRIEF.md
# Field-Counted Blink Timer

This block generates the gate that makes blinking characters flash on an on-screen text overlay. It watches the active-low vertical sync input and brings it into the local clock domain. Each field start, seen as a falling edge of that sync, advances a free-running 6-bit phase counter. The counter wraps every 64 fields, so one full blink cycle lasts about one second at normal field rates.

A 2-bit ratio select picks how the blink cycle is split between the visible and blanked parts. The top two counter bits are decoded into the single `blink_on` output. Display logic outside this block ANDs `blink_on` with the blink attribute of each character. The field-start edge is the only event that moves the counter, and a change of the ratio select alters only the decode, never the phase.

Top module: `blink_timer`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) clears the phase counter to 0. At phase 0, blink_on is 1 for every ratio_sel value.
- R2: Each high-to-low transition of vsync_n advances the phase counter by exactly one. This holds for any low width of at least one clock period.
- R3: A vsync_n that stays low, or stays high, for any number of cycles does not advance the counter. A low-to-high transition does not advance it either.
- R4: The phase counter is 6 bits wide and wraps from 63 to 0, so the blink cycle is 64 field starts long.
- R5: ratio_sel = 2'b00 selects 1:1. blink_on is 1 when counter bit 5 is 0, which gives 32 fields on and 32 fields off.
- R6: ratio_sel = 2'b01 selects 1:3. blink_on is 1 only when counter bits [5:4] are 2'b00, which gives 16 fields on and 48 fields off.
- R7: ratio_sel = 2'b10 selects 3:1. blink_on is 1 unless counter bits [5:4] are 2'b11, which gives 48 fields on and 16 fields off.
- R8: ratio_sel = 2'b11 behaves exactly as 2'b00.
- R9: The edge of the synchronizer that first captures vsync_n low is counted as edge 1. blink_on shows the new phase after rising clock edge 3 and still shows the old phase after edge 2.
- R10: blink_on follows a change of ratio_sel without waiting for a clock edge, and the change leaves the phase counter untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_n | input | 1 | Asynchronous active-low vertical sync |
| ratio_sel | input | 2 | Blink on:off ratio select |
| blink_on | output | 1 | High when blinking characters are to be shown |

## Verification
The phase cannot be read directly, so a wrong counter state shows up only as a `blink_on` transition in the wrong field. A missed or doubled count moves every later transition by one field, and the 16-field boundaries make that visible within at most 16 field starts. The bench therefore runs all four ratios over a full 64-field wrap. It also checks edges at the 31/32 and 46/47/48 boundaries, where a single count of error flips the output straight away.

// File: rtl/blink_pkg.sv
// Package: shared types for the blink timer.
// Assumes: ratio select is a 2-bit field whose encoding is defined here.
package blink_pkg;

    typedef enum logic [1:0] {
        RATIO_EVEN  = 2'b00,   // 1:1
        RATIO_SHORT = 2'b01,   // 1:3 (short on time)
        RATIO_LONG  = 2'b10,   // 3:1 (long on time)
        RATIO_ALT   = 2'b11    // alias of 1:1
    } ratio_t;

endpackage

// File: rtl/vsync_edge.sv
// Module: vsync_edge
// Brings the asynchronous active-low vertical sync into the clk domain
// through STAGES flops and flags one cycle per high-to-low transition.
// Assumes: STAGES >= 2; the sync low time covers at least one clk period.
module vsync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_n,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Stage 0 captures the raw input; idle level after reset is high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b1;
        else        sync_q[0] <= vsync_n;
    end

    // Remaining stages shift the captured level toward the edge detector.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[g] <= 1'b1;
            else        sync_q[g] <= sync_q[g-1];
        end
    end

    // Holds the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= sync_q[STAGES-1];
    end

    assign fall_o = last_q & ~sync_q[STAGES-1];

    // A falling edge is flagged for a single cycle only.
    assert_one_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/phase_counter.sv
// Module: phase_counter
// Free-running field counter advanced only by step_i; wraps at 2**CNT_W.
// Exposes only its top two bits, which are all the decoder needs.
// Assumes: CNT_W >= 2.
module phase_counter #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    output logic [1:0] phase_o
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    // Advances the phase once per detected field start.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (step_i) count_q <= count_q + 1'b1;
    end

    assign phase_o = count_q[CNT_W-1 -: 2];

    // Reset always leaves the counter at zero.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> count_q == '0);

    // One step per flagged edge.
    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> count_q == $past(count_q) + 1'b1);

    // No movement without a flagged edge.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(count_q));

    // The last value rolls over to zero.
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && count_q == TOP) |=> count_q == '0);

endmodule

// File: rtl/ratio_decode.sv
// Module: ratio_decode
// Turns the top two phase bits into the visible gate for the chosen ratio.
// Purely combinational; the clock and reset serve only the checks.
// Assumes: phase_i is the two most significant counter bits.
module ratio_decode
    import blink_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] phase_i,
    input  ratio_t     sel_i,
    output logic       vis_o
);

    logic vis_half, vis_short, vis_long;

    // Candidate gates for each ratio, derived from the quadrant of the period.
    always_comb begin
        vis_half  = ~phase_i[1];
        vis_short = (phase_i == 2'b00);
        vis_long  = (phase_i != 2'b11);
    end

    // Picks the gate named by the ratio select.
    always_comb begin
        unique case (sel_i)
            RATIO_SHORT: vis_o = vis_short;
            RATIO_LONG:  vis_o = vis_long;
            default:     vis_o = vis_half;
        endcase
    end

    // The 1:3 window lies inside the 1:1 window.
    assert_short_in_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vis_short |-> vis_half);

    // The 1:1 window lies inside the 3:1 window.
    assert_half_in_long_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vis_half |-> vis_long);

    // The alias code shows the same gate as the 1:1 code.
    assert_alias_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == RATIO_ALT) |-> (vis_o == ~phase_i[1]));

endmodule

// File: rtl/blink_timer.sv
// Module: blink_timer (top)
// Field-counted blink gate: synchronizer and edge detector, 6-bit phase
// counter, and ratio decoder.
// Assumes: vsync_n is asynchronous to clk and is low for at least one clk
// period per field.
module blink_timer
    import blink_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsync_n,
    input  logic [1:0] ratio_sel,
    output logic       blink_on
);

    logic       field_start;
    logic [1:0] phase;
    ratio_t     sel;

    assign sel = ratio_t'(ratio_sel);

    vsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsync_n (vsync_n),
        .fall_o  (field_start)
    );

    phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (field_start),
        .phase_o (phase)
    );

    ratio_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase),
        .sel_i   (sel),
        .vis_o   (blink_on)
    );

endmodule

// File: tb/sim_blink_timer.sv
// Bench for blink_timer: a driver produces field pulses and queues the expected
// gate value. A negedge monitor pops each item and compares it with blink_on.
module sim_blink_timer;

    logic clk = 1'b0;
    logic rst_n;
    logic vsync_n;
    logic [1:0] ratio_sel;
    logic blink_on;

    always #10 clk = ~clk;   // 50 MHz

    blink_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync_n   (vsync_n),
        .ratio_sel (ratio_sel),
        .blink_on  (blink_on)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t q[$];
    int    n_run = 0;
    int    n_fail = 0;
    int    model_cnt = 0;
    logic  sample_req = 1'b0;
    bit    done = 1'b0;

    // Expected gate value from the ratio rules in the requirements.
    function automatic logic exp_vis(int cnt, logic [1:0] sel);
        logic [1:0] top;
        top = 2'(cnt >> 4);
        case (sel)
            2'b01:   return top == 2'b00;   // R6
            2'b10:   return top != 2'b11;   // R7
            default: return top[1] == 1'b0; // R5, R8
        endcase
    endfunction

    function automatic string sel_tag(logic [1:0] sel);
        case (sel)
            2'b00:   return "R5";
            2'b01:   return "R6";
            2'b10:   return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(logic exp, string tag);
        n_run++;
        if (blink_on !== exp) begin
            n_fail++;
            $display("FAIL %s: blink_on=%0b expected %0b (count %0d sel %0b)",
                     tag, blink_on, exp, model_cnt, ratio_sel);
        end
    endtask

    // Monitor: compares the queued expectation at a falling edge.
    always @(negedge clk) begin
        if (sample_req) begin
            item_t it;
            it = q.pop_front();
            check(it.exp, it.tag);
            sample_req = 1'b0;
        end
    end

    task automatic push(logic exp, string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
        @(posedge clk);
        sample_req = 1'b1;
        wait (sample_req == 1'b0);
    endtask

    // One field pulse of the given low width; waits until the count settles.
    task automatic pulse(int low);
        @(negedge clk) vsync_n = 1'b0;
        repeat (low) @(negedge clk);
        vsync_n = 1'b1;
        repeat (4) @(negedge clk);
        model_cnt = (model_cnt + 1) % 64;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        vsync_n = 1'b1;
        ratio_sel = 2'b00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: phase 0 after reset is visible under every ratio
        for (int s = 0; s < 4; s++) begin
            ratio_sel = 2'(s);
            #1 check(1'b1, "R1 reset phase visible");
        end
        ratio_sel = 2'b00;

        // Advance to 31 with sel 00, then check R9 latency across the 31->32 boundary
        for (int i = 0; i < 31; i++) pulse(1);
        @(negedge clk) vsync_n = 1'b0;
        @(negedge clk) check(1'b1, "R9 after edge 1");
        @(negedge clk) check(1'b1, "R9 after edge 2");
        @(negedge clk) check(1'b0, "R9 after edge 3");
        model_cnt = 32;
        repeat (10) @(negedge clk);
        check(1'b0, "R3 long low holds count");
        vsync_n = 1'b1;
        repeat (10) @(negedge clk);
        check(1'b0, "R3 high level holds count");

        // R3: long low pulse from 46 must land at 47 (visible in 3:1), not 48
        ratio_sel = 2'b10;
        while (model_cnt != 46) pulse(2);
        pulse(30);
        push(exp_vis(model_cnt, ratio_sel), "R3 long low single step 47");
        pulse(1);
        push(exp_vis(model_cnt, ratio_sel), "R7 boundary 48");

        // R10: switching the ratio changes the decode only, never the phase
        for (int s = 0; s < 4; s++) begin
            @(negedge clk) ratio_sel = 2'(s);
            #1 check(exp_vis(model_cnt, 2'(s)), "R10 immediate ratio change");
        end
        for (int s = 3; s >= 0; s--) begin
            @(negedge clk) ratio_sel = 2'(s);
            #1 check(exp_vis(model_cnt, 2'(s)), "R10 phase kept after changes");
        end

        // R2/R4 with R5..R8: full periods per ratio with varying low widths
        for (int s = 0; s < 4; s++) begin
            ratio_sel = 2'(s);
            for (int i = 0; i < 64; i++) begin
                bit wrap;
                wrap = (model_cnt == 63);
                pulse((i % 5) + 1);
                push(exp_vis(model_cnt, ratio_sel),
                     wrap ? "R4 wrap 63 to 0" : {"R2 step, ", sel_tag(ratio_sel)});
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule